// File: doc/BRIEF.md
# I2C Bus Condition Generator

This block owns the two open-drain lines of an I2C master, SCL and SDA. In pass-through mode it forwards the clock and data levels produced by a separate shift engine. While it forwards them, it watches those levels and pulses an interrupt whenever a START or STOP condition appears on them. In generator mode it ignores the shift engine and plays out START, repeated-START or STOP waveforms on its own. Each phase of a waveform lasts a programmable number of clock cycles.

Software first sets one or more request bits and then raises the select input, which hands the lines to the generator. The generator serves one pending request at a time. When a waveform finishes, the block clears the request bit that was served and pulses the same interrupt output. Levels are described as released (1) or pulled low (0). The outputs are drive-low enables, so an output of 1 pulls the line low.

Top module: `i2c_cond_gen`

## Requirements
- R1: While reset is asserted and in the first cycle after it, both drive-low outputs are 0, the pending status is 0 and the interrupt is 0.
- R2: With select at 0 and no waveform in progress, each drive-low output is the inverse of the matching shift-engine level. No waveform starts, and pending bits only accumulate.
- R3: A one-cycle set strobe sets its pending bit: bit 0 for START, bit 1 for repeated START, bit 2 for STOP. The bit stays set until its own waveform completes. It is cleared only in the cycle the interrupt pulses for that completion, unless a new strobe arrives in that same cycle.
- R4: When select is 1, no waveform is running and any pending bit is set, a waveform begins at the next clock edge. STOP is chosen over repeated START, and repeated START over START. Only one waveform runs at a time.
- R5: START, with half period H: SCL released and SDA low for H cycles, then both low.
- R6: Repeated START: SCL low and SDA released for H cycles, then both released for H cycles, then SCL released and SDA low for H cycles, then both low.
- R7: STOP: both low for H cycles, then SCL released and SDA low for H cycles, then both released.
- R8: In generator mode the interrupt is a single-cycle pulse. It appears in the same cycle as the final line levels and the cleared pending bit.
- R9: In pass-through mode the interrupt pulses one cycle after a sampled edge on the engine's SDA while the engine's SCL is released in both samples. A falling edge is a START and a rising edge is a STOP.
- R10: A half period of 0 behaves as a half period of 1.
- R11: A waveform that has begun runs to completion even if select drops. The lines stay with the generator until it completes.
- R12: With select at 1 and nothing pending, the lines hold the final levels of the last waveform.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| half_period_i | input | CNT_W (16) | Cycles per waveform phase |
| sel_i | input | 1 | 1 hands the lines to the generator |
| set_start_i | input | 1 | Set strobe for the START request |
| set_restart_i | input | 1 | Set strobe for the repeated-START request |
| set_stop_i | input | 1 | Set strobe for the STOP request |
| eng_scl_i | input | 1 | Shift engine clock level (1 released) |
| eng_sda_i | input | 1 | Shift engine data level (1 released) |
| scl_drive_low_o | output | 1 | 1 pulls SCL low |
| sda_drive_low_o | output | 1 | 1 pulls SDA low |
| done_irq_o | output | 1 | Completion or detection pulse |
| req_pend_o | output | 3 | Pending requests {stop, restart, start} |

## Verification
Two situations are hard to reach from the ports. The first is a request strobe that arrives while a waveform is in progress. The second is select falling in the middle of a waveform, because both depend on landing a stimulus inside a window only a few cycles wide. The bench sets half periods of several cycles, counts edges from the start of a waveform, and injects a STOP strobe while a START is still running. In a separate run it drops select during the second phase of a repeated START. A behavioural model queues the per-cycle expected levels of every waveform and compares the outputs with them on every clock, so a one-cycle slip in any phase is caught.

// File: rtl/i2c_cond_pkg.sv
package i2c_cond_pkg;
  typedef enum logic [1:0] {
    K_NONE    = 2'd0,
    K_START   = 2'd1,
    K_RESTART = 2'd2,
    K_STOP    = 2'd3
  } cond_e;

  typedef struct packed {
    logic scl;
    logic sda;
  } lvl_t;

  function automatic lvl_t phase_lvl(cond_e k, logic [1:0] ph);
    lvl_t l;
    l = '{scl: 1'b1, sda: 1'b1};
    case (k)
      K_START:   l = '{scl: 1'b1, sda: 1'b0};
      K_RESTART: begin
        if (ph == 2'd0)      l = '{scl: 1'b0, sda: 1'b1};
        else if (ph == 2'd1) l = '{scl: 1'b1, sda: 1'b1};
        else                 l = '{scl: 1'b1, sda: 1'b0};
      end
      K_STOP:    l = (ph == 2'd0) ? '{scl: 1'b0, sda: 1'b0} : '{scl: 1'b1, sda: 1'b0};
      default:   l = '{scl: 1'b1, sda: 1'b1};
    endcase
    return l;
  endfunction

  function automatic logic [1:0] last_phase(cond_e k);
    case (k)
      K_RESTART: return 2'd2;
      K_STOP:    return 2'd1;
      default:   return 2'd0;
    endcase
  endfunction

  function automatic lvl_t final_lvl(cond_e k);
    return (k == K_STOP) ? '{scl: 1'b1, sda: 1'b1} : '{scl: 1'b0, sda: 1'b0};
  endfunction

  // pending bit index: 0 start, 1 restart, 2 stop
  function automatic logic [2:0] kind_mask(cond_e k);
    case (k)
      K_START:   return 3'b001;
      K_RESTART: return 3'b010;
      K_STOP:    return 3'b100;
      default:   return 3'b000;
    endcase
  endfunction
endpackage

// File: rtl/i2c_cond_req.sv
module i2c_cond_req
  import i2c_cond_pkg::*;
#(
  parameter int NREQ = 3
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic [NREQ-1:0] set_i,
  input  logic [NREQ-1:0] clr_i,
  output logic [NREQ-1:0] pend_o,
  output cond_e           pick_o
);
  logic [NREQ-1:0] pend_q;

  for (genvar i = 0; i < NREQ; i++) begin : g_bit
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) pend_q[i] <= 1'b0;
      else         pend_q[i] <= (pend_q[i] & ~clr_i[i]) | set_i[i];
    end
  end

  always_comb begin
    if (pend_q[2])      pick_o = K_STOP;
    else if (pend_q[1]) pick_o = K_RESTART;
    else if (pend_q[0]) pick_o = K_START;
    else                pick_o = K_NONE;
  end

  assign pend_o = pend_q;
endmodule

// File: rtl/i2c_cond_seq.sv
module i2c_cond_seq
  import i2c_cond_pkg::*;
#(
  parameter int CNT_W = 16
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [CNT_W-1:0] half_i,
  input  logic             go_i,
  input  cond_e            kind_i,
  input  logic             track_i,
  input  lvl_t             eng_i,
  output logic             busy_o,
  output logic             fin_o,
  output cond_e            kind_o,
  output lvl_t             lvl_o
);
  logic             busy_q;
  cond_e            kind_q;
  logic [1:0]       ph_q;
  logic [CNT_W-1:0] cnt_q;
  logic [CNT_W-1:0] lim;
  lvl_t             lvl_q;
  logic             wrap;

  assign lim   = (half_i == '0) ? '0 : half_i - 1'b1;
  assign wrap  = busy_q && (cnt_q >= lim);
  assign fin_o = wrap && (ph_q == last_phase(kind_q));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      busy_q <= 1'b0;
      kind_q <= K_NONE;
      ph_q   <= '0;
      cnt_q  <= '0;
      lvl_q  <= '{scl: 1'b1, sda: 1'b1};
    end else if (busy_q) begin
      if (wrap) begin
        cnt_q <= '0;
        if (fin_o) begin
          busy_q <= 1'b0;
          lvl_q  <= final_lvl(kind_q);
        end else begin
          ph_q  <= ph_q + 2'd1;
          lvl_q <= phase_lvl(kind_q, ph_q + 2'd1);
        end
      end else begin
        cnt_q <= cnt_q + 1'b1;
      end
    end else if (go_i) begin
      busy_q <= 1'b1;
      kind_q <= kind_i;
      ph_q   <= '0;
      cnt_q  <= '0;
      lvl_q  <= phase_lvl(kind_i, 2'd0);
    end else if (track_i) begin
      lvl_q <= eng_i;  // start from the engine's levels on hand-over
    end
  end

  assign busy_o = busy_q;
  assign kind_o = kind_q;
  assign lvl_o  = lvl_q;
endmodule

// File: rtl/i2c_cond_det.sv
module i2c_cond_det (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic en_i,
  input  logic scl_i,
  input  logic sda_i,
  output logic hit_o
);
  logic scl_q, sda_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      scl_q <= 1'b1;
      sda_q <= 1'b1;
    end else begin
      scl_q <= scl_i;
      sda_q <= sda_i;
    end
  end

  assign hit_o = en_i && scl_q && scl_i && (sda_q ^ sda_i);
endmodule

// File: rtl/i2c_cond_gen.sv
module i2c_cond_gen
  import i2c_cond_pkg::*;
#(
  parameter int CNT_W = 16
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [CNT_W-1:0] half_period_i,
  input  logic             sel_i,
  input  logic             set_start_i,
  input  logic             set_restart_i,
  input  logic             set_stop_i,
  input  logic             eng_scl_i,
  input  logic             eng_sda_i,
  output logic             scl_drive_low_o,
  output logic             sda_drive_low_o,
  output logic             done_irq_o,
  output logic [2:0]       req_pend_o
);
  logic  busy, fin, go, pass, hit, irq_q, gen_on;
  logic [2:0] set_v, clr_v, pend;
  cond_e pick, kind;
  lvl_t  lvl, eng;

  assign set_v = {set_stop_i, set_restart_i, set_start_i};
  assign eng   = '{scl: eng_scl_i, sda: eng_sda_i};
  assign pass  = !sel_i && !busy;
  assign go    = sel_i && !busy && (|pend);
  assign clr_v = fin ? kind_mask(kind) : 3'b000;

  i2c_cond_req #(.NREQ(3)) u_req (
    .clk_i (clk_i), .rst_ni(rst_ni), .set_i(set_v), .clr_i(clr_v),
    .pend_o(pend), .pick_o(pick)
  );

  i2c_cond_seq #(.CNT_W(CNT_W)) u_seq (
    .clk_i (clk_i), .rst_ni(rst_ni), .half_i(half_period_i), .go_i(go),
    .kind_i(pick), .track_i(pass), .eng_i(eng), .busy_o(busy),
    .fin_o (fin), .kind_o(kind), .lvl_o(lvl)
  );

  i2c_cond_det u_det (
    .clk_i(clk_i), .rst_ni(rst_ni), .en_i(pass), .scl_i(eng_scl_i),
    .sda_i(eng_sda_i), .hit_o(hit)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) irq_q <= 1'b0;
    else         irq_q <= fin | hit;
  end

  assign gen_on          = sel_i || busy;
  assign scl_drive_low_o = !(gen_on ? lvl.scl : eng_scl_i);
  assign sda_drive_low_o = !(gen_on ? lvl.sda : eng_sda_i);
  assign done_irq_o      = irq_q;
  assign req_pend_o      = pend;
endmodule

// File: rtl/i2c_cond_gen_chk.sv
module i2c_cond_gen_chk (
  input logic       clk_i,
  input logic       rst_ni,
  input logic       sel_i,
  input logic       busy,
  input logic [2:0] set_v,
  input logic [2:0] req_pend_o,
  input logic       scl_drive_low_o,
  input logic       sda_drive_low_o,
  input logic       done_irq_o
);
  a_r3_clear_only_with_irq: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (|($past(req_pend_o) & ~req_pend_o)) |-> done_irq_o);

  a_r4_single_completion: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $countones($past(req_pend_o) & ~req_pend_o) <= 1);

  a_r7_stop_ends_released: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($fell(req_pend_o[2]) && sel_i) |-> (!scl_drive_low_o && !sda_drive_low_o));

  a_r5_start_ends_low: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (($fell(req_pend_o[0]) || $fell(req_pend_o[1])) && sel_i)
      |-> (scl_drive_low_o && sda_drive_low_o));

  a_r2_pass_keeps_pending: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!sel_i && !busy && (set_v == 3'b000)) |=> $stable(req_pend_o));

  a_r8_irq_single_in_gen: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (done_irq_o && sel_i && $past(sel_i) && $past(busy)) |=> !done_irq_o);
endmodule

bind i2c_cond_gen i2c_cond_gen_chk u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .sel_i(sel_i), .busy(busy), .set_v(set_v),
  .req_pend_o(req_pend_o), .scl_drive_low_o(scl_drive_low_o),
  .sda_drive_low_o(sda_drive_low_o), .done_irq_o(done_irq_o)
);

// File: tb/tb_i2c_cond_gen.sv
`timescale 1ns/1ps
module tb_i2c_cond_gen;
  logic        clk = 0;
  logic        rst_n = 0;
  logic [15:0] half = 16'd3;
  logic        sel = 0, s_start = 0, s_restart = 0, s_stop = 0;
  logic        escl = 1, esda = 1;
  logic        scl_dl, sda_dl, irq;
  logic [2:0]  pend;

  int    errors = 0, checks = 0;
  string cur_req = "R1";
  bit    finished = 0;

  always #4 clk = ~clk;

  i2c_cond_gen dut (
    .clk_i(clk), .rst_ni(rst_n), .half_period_i(half), .sel_i(sel),
    .set_start_i(s_start), .set_restart_i(s_restart), .set_stop_i(s_stop),
    .eng_scl_i(escl), .eng_sda_i(esda), .scl_drive_low_o(scl_dl),
    .sda_drive_low_o(sda_dl), .done_irq_o(irq), .req_pend_o(pend)
  );

  // reference model; levels are {scl,sda}, 1 = released
  logic [2:0] m_pend = 0;
  logic       m_busy = 0, m_irq = 0, p_scl = 1, p_sda = 1;
  logic [1:0] m_lvl = 2'b11;
  int         m_kind = 0;
  logic [2:0] q[$];

  task automatic push_phase(logic [1:0] l, int h);
    for (int i = 0; i < h; i++) q.push_back({1'b0, l});
  endtask

  always @(posedge clk) begin
    if (!rst_n) begin
      m_pend = 0; m_busy = 0; m_irq = 0; m_lvl = 2'b11; p_scl = 1; p_sda = 1;
      q.delete();
    end else begin
      logic       irq_n, hit;
      logic [2:0] clr, e, setv;
      int         h;
      irq_n = 0; clr = 0; setv = {s_stop, s_restart, s_start};
      hit = !sel && !m_busy && p_scl && escl && (p_sda != esda);
      h = (half == 0) ? 1 : int'(half);
      if (m_busy) begin
        e = q.pop_front();
        m_lvl = e[1:0];
        if (e[2]) begin
          m_busy = 0; irq_n = 1;
          clr = (m_kind == 3) ? 3'b100 : (m_kind == 2) ? 3'b010 : 3'b001;
        end
      end else if (sel && m_pend != 0) begin
        m_kind = m_pend[2] ? 3 : m_pend[1] ? 2 : 1;
        q.delete();
        if (m_kind == 1) begin
          push_phase(2'b10, h); q.push_back(3'b100);
        end else if (m_kind == 2) begin
          push_phase(2'b01, h); push_phase(2'b11, h); push_phase(2'b10, h);
          q.push_back(3'b100);
        end else begin
          push_phase(2'b00, h); push_phase(2'b10, h); q.push_back(3'b111);
        end
        e = q.pop_front(); m_lvl = e[1:0]; m_busy = 1;
      end else if (!sel) begin
        m_lvl = {escl, esda};
      end
      if (hit) irq_n = 1;
      m_pend = (m_pend & ~clr) | setv;
      p_scl = escl; p_sda = esda; m_irq = irq_n;
    end
  end

  // compare every cycle, mid-period
  always @(negedge clk) begin
    #3;
    if (!finished) begin
      logic       on;
      logic [1:0] lv;
      logic [4:0] exp_v, act_v;
      on = sel || m_busy;
      lv = on ? m_lvl : {escl, esda};
      exp_v = {!lv[1], !lv[0], m_irq, m_pend};
      act_v = {scl_dl, sda_dl, irq, pend};
      checks++;
      if (act_v !== exp_v) begin
        errors++;
        $display("FAIL %s t=%0t {scl_dl,sda_dl,irq,pend} actual=%b expected=%b",
                 cur_req, $time, act_v, exp_v);
      end
    end
  end

  task automatic tick(int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic strobe(logic [2:0] m);
    @(negedge clk);
    {s_stop, s_restart, s_start} = m;
    @(negedge clk);
    {s_stop, s_restart, s_start} = 3'b000;
  endtask

  initial begin
    // R1: reset values
    tick(4);
    rst_n = 1;
    tick(2);

    // R2: pass-through, pending bit set but nothing generated
    cur_req = "R2";
    strobe(3'b001);
    for (int i = 0; i < 30; i++) begin
      @(negedge clk);
      escl = 1'($urandom_range(0, 1));
      esda = 1'($urandom_range(0, 1));
    end

    // R9: clean start then stop on the engine lines
    cur_req = "R9";
    @(negedge clk); escl = 1; esda = 1;
    tick(3); esda = 0;
    tick(3); escl = 0;
    tick(2); escl = 1;
    tick(2); esda = 1;
    tick(3);

    // R5: START with H=3, pending start from R2
    cur_req = "R5";
    half = 3; sel = 1;
    tick(8);
    // R12: hold final levels
    cur_req = "R12";
    tick(6);
    sel = 0; tick(2);

    // R6: repeated START with H=2
    cur_req = "R6";
    half = 2; strobe(3'b010); sel = 1;
    tick(12);
    sel = 0; tick(2);

    // R7: STOP with H=4
    cur_req = "R7";
    half = 4; strobe(3'b100); sel = 1;
    tick(14);
    sel = 0; tick(2);

    // R4: all three pending, served stop, restart, start
    cur_req = "R4";
    half = 2; strobe(3'b111); sel = 1;
    tick(30);
    sel = 0; tick(2);

    // R8: H=1 START, back-to-back pulse timing
    cur_req = "R8";
    half = 1; strobe(3'b001); sel = 1;
    tick(5);
    sel = 0; tick(2);

    // R3: STOP strobe lands while a START is running
    cur_req = "R3";
    half = 5; strobe(3'b001); sel = 1;
    tick(2);
    strobe(3'b100);
    tick(1);
    strobe(3'b001);
    tick(30);
    sel = 0; tick(2);

    // R10: half period 0
    cur_req = "R10";
    half = 0; strobe(3'b100); sel = 1;
    tick(8);
    sel = 0; tick(2);

    // R11: select drops mid-sequence, engine moves meanwhile
    cur_req = "R11";
    half = 6; strobe(3'b010); sel = 1;
    tick(8);
    sel = 0;
    for (int i = 0; i < 20; i++) begin
      @(negedge clk);
      esda = ~esda;
    end
    tick(4);

    finished = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    #(200000 * 8);
    if (!finished) begin
      finished = 1;
      errors++; checks++;
      $display("FAIL watchdog: run did not end, actual=hung expected=done");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule